// File: doc/BRIEF.md
# Per-Interrupt Distributor State Tracker

This block holds the per-interrupt bookkeeping of a small interrupt distributor that serves several processors. For every interrupt it stores enable, latched-pending, active, group and sampled-line-level bits, each as a mask with one bit per processor. It also stores a trigger flag (edge or level), a one-of-N delivery flag and a priority value. Priorities are banked per processor for the low, processor-private interrupt numbers and shared for the rest.

Software-side logic issues set or clear commands that carry a processor mask. The block samples every interrupt line once per clock and latches pending on rising edges. It answers combinational queries for one chosen interrupt and processor. Pending is derived rather than stored: a level-triggered interrupt whose sampled line is high reads as pending even with its latch clear. A compile-time legacy mode drops that level term.

Top module: `irq_state_tracker`

## Requirements
- R1: A set command (`cmd_set`=1) ORs `cmd_mask` into the selected field of interrupt `cmd_irq`; field codes are 0 enable, 1 pending, 2 active, 3 group; the result is visible from the clock edge that accepts the command.
- R2: A clear command (`cmd_set`=0) ANDs the inverse of `cmd_mask` into the selected field; an all-zero mask leaves the field unchanged.
- R3: With the legacy mode off, a level-triggered interrupt (`cfg_edge`=0) reads pending for a processor when its latched bit is set or when that processor's sampled line bit is high; lines are sampled at every clock edge.
- R4: An edge-triggered interrupt (`cfg_edge`=1) latches pending for a processor only on a 0-to-1 change of that processor's line between two samples; a line that stays high latches nothing new.
- R5: Clearing pending on an interrupt whose one-of-N flag is set (`cfg_model`=1) clears the latched bit of every processor, whatever the mask.
- R6: Clearing pending on an interrupt whose one-of-N flag is clear affects only the processors in the mask.
- R7: Clearing the latched pending bit of a level-triggered interrupt whose line is still high leaves it reading pending; it stops reading pending once the line has been sampled low.
- R8: Interrupts numbered below `NINT` keep a separate priority per processor; interrupts at or above `NINT` hold one priority that any processor's write replaces and every processor reads.
- R9: With `LEGACY_REV`=1 the level term is dropped: a rising line edge latches pending whatever the trigger flag, and pending reads only from the latch.
- R10: Reset clears every state bit, flag and priority to zero.
- R11: A rising edge that latches pending in the same cycle as a clear-pending command on that interrupt wins: the bit reads set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NIRQ*NCPU | Interrupt lines, bit irq*NCPU+cpu |
| cmd_valid | input | 1 | Command strobe |
| cmd_set | input | 1 | 1 = set, 0 = clear |
| cmd_field | input | 2 | 0 enable, 1 pending, 2 active, 3 group |
| cmd_irq | input | IW | Target interrupt |
| cmd_mask | input | NCPU | Processor mask |
| cfg_valid | input | 1 | Trigger/model configuration strobe |
| cfg_irq | input | IW | Interrupt to configure |
| cfg_edge | input | 1 | 1 = edge-triggered |
| cfg_model | input | 1 | 1 = one-of-N delivery |
| pri_we | input | 1 | Priority write strobe |
| pri_irq | input | IW | Interrupt whose priority is written |
| pri_cpu | input | CW | Writing processor (bank select below NINT) |
| pri_val | input | PW | Priority value |
| q_irq | input | IW | Queried interrupt |
| q_cpu | input | CW | Queried processor |
| q_enabled | output | 1 | Enable bit |
| q_pending | output | 1 | Derived pending status |
| q_active | output | 1 | Active bit |
| q_group | output | 1 | Group bit |
| q_priority | output | PW | Priority seen by the processor |

## Verification
A table of set and clear commands on every field, with single-bit, both-bit and empty masks, shows whether masks OR in, AND out, or leave bits alone. Line waveforms on a level interrupt, an edge interrupt and a legacy-mode copy tell the level term apart from the edge latch, and show whether a held-high line re-latches after a clear. A one-of-N interrupt cleared with a one-bit mask separates the broadcast clear from the masked one. Priority writes from both processors on a banked and a shared number separate per-processor storage from common storage. A clear issued on the same edge as a rising line shows which of the two wins.

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
  parameter int NCPU       = 2,
  parameter int NIRQ       = 64,
  parameter int NINT       = 32,
  parameter int PW         = 8,
  parameter bit LEGACY_REV = 1'b0,
  localparam int IW = $clog2(NIRQ),
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIRQ*NCPU-1:0] line_in,
  input  logic                 cmd_valid,
  input  logic                 cmd_set,
  input  logic [1:0]           cmd_field,
  input  logic [IW-1:0]        cmd_irq,
  input  logic [NCPU-1:0]      cmd_mask,
  input  logic                 cfg_valid,
  input  logic [IW-1:0]        cfg_irq,
  input  logic                 cfg_edge,
  input  logic                 cfg_model,
  input  logic                 pri_we,
  input  logic [IW-1:0]        pri_irq,
  input  logic [CW-1:0]        pri_cpu,
  input  logic [PW-1:0]        pri_val,
  input  logic [IW-1:0]        q_irq,
  input  logic [CW-1:0]        q_cpu,
  output logic                 q_enabled,
  output logic                 q_pending,
  output logic                 q_active,
  output logic                 q_group,
  output logic [PW-1:0]        q_priority
);
  localparam int NW = (NINT > 1) ? $clog2(NINT) : 1;
  localparam int SW = (NIRQ - NINT > 1) ? $clog2(NIRQ - NINT) : 1;
  localparam logic [NCPU-1:0] ALL = {NCPU{1'b1}};

  logic [NIRQ-1:0][NCPU-1:0] en_q, pend_q, act_q, grp_q, lvl_q;
  logic [NIRQ-1:0][NCPU-1:0] en_d, pend_d, act_d, grp_d;
  logic [NIRQ-1:0][NCPU-1:0] line_v, rise;
  logic [NIRQ-1:0]           edge_q, model_q;
  logic [NINT-1:0][NCPU-1:0][PW-1:0] pri_bank;
  logic [NIRQ-NINT-1:0][PW-1:0]      pri_shr;
  logic [IW-1:0] pri_off, q_off;
  logic          lvl_term;

  assign line_v  = line_in;
  assign rise    = line_v & ~lvl_q;
  assign pri_off = pri_irq - IW'(NINT);
  assign q_off   = q_irq - IW'(NINT);

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    act_d  = act_q;
    grp_d  = grp_q;
    for (int i = 0; i < NIRQ; i++) begin
      if (cmd_valid && cmd_irq == IW'(i)) begin
        case (cmd_field)
          2'd0: en_d[i] = cmd_set ? (en_q[i] | cmd_mask) : (en_q[i] & ~cmd_mask);
          2'd1: pend_d[i] = cmd_set ? (pend_q[i] | cmd_mask)
                                    : (pend_q[i] & ~(model_q[i] ? ALL : cmd_mask));
          2'd2: act_d[i] = cmd_set ? (act_q[i] | cmd_mask) : (act_q[i] & ~cmd_mask);
          default: grp_d[i] = cmd_set ? (grp_q[i] | cmd_mask) : (grp_q[i] & ~cmd_mask);
        endcase
      end
      if (LEGACY_REV || edge_q[i]) pend_d[i] = pend_d[i] | rise[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      pend_q   <= '0;
      act_q    <= '0;
      grp_q    <= '0;
      lvl_q    <= '0;
      edge_q   <= '0;
      model_q  <= '0;
      pri_bank <= '0;
      pri_shr  <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      grp_q  <= grp_d;
      lvl_q  <= line_v;
      if (cfg_valid) begin
        edge_q[cfg_irq]  <= cfg_edge;
        model_q[cfg_irq] <= cfg_model;
      end
      if (pri_we) begin
        if (pri_irq < IW'(NINT)) pri_bank[pri_irq[NW-1:0]][pri_cpu] <= pri_val;
        else                     pri_shr[pri_off[SW-1:0]]            <= pri_val;
      end
    end
  end

  generate
    if (LEGACY_REV) begin : g_legacy
      assign lvl_term = 1'b0;
    end else begin : g_level
      assign lvl_term = !edge_q[q_irq] && lvl_q[q_irq][q_cpu];
    end
  endgenerate

  assign q_enabled  = en_q[q_irq][q_cpu];
  assign q_active   = act_q[q_irq][q_cpu];
  assign q_group    = grp_q[q_irq][q_cpu];
  assign q_pending  = pend_q[q_irq][q_cpu] | lvl_term;
  assign q_priority = (q_irq < IW'(NINT)) ? pri_bank[q_irq[NW-1:0]][q_cpu]
                                          : pri_shr[q_off[SW-1:0]];
endmodule

module irq_state_tracker_chk #(
  parameter int NCPU       = 2,
  parameter int NIRQ       = 64,
  parameter bit LEGACY_REV = 1'b0,
  localparam int IW = $clog2(NIRQ),
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmd_valid,
  input logic                      cmd_set,
  input logic [1:0]                cmd_field,
  input logic [IW-1:0]             cmd_irq,
  input logic [NCPU-1:0]           cmd_mask,
  input logic [IW-1:0]             q_irq,
  input logic [CW-1:0]             q_cpu,
  input logic                      q_pending,
  input logic [NIRQ-1:0][NCPU-1:0] en_q,
  input logic [NIRQ-1:0][NCPU-1:0] pend_q,
  input logic [NIRQ-1:0][NCPU-1:0] lvl_q,
  input logic [NIRQ-1:0][NCPU-1:0] rise,
  input logic [NIRQ-1:0]           edge_q,
  input logic [NIRQ-1:0]           model_q
);
  AST_SET_ORS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_set && cmd_field == 2'd0)
    |=> ((en_q[$past(cmd_irq)] & $past(cmd_mask)) == $past(cmd_mask))); // R1

  AST_CLR_ANDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_set && cmd_field == 2'd0)
    |=> ((en_q[$past(cmd_irq)] & $past(cmd_mask)) == '0)); // R2

  AST_LEVEL_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!LEGACY_REV && !edge_q[q_irq] && lvl_q[q_irq][q_cpu]) |-> q_pending); // R3

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q[q_irq] && rise[q_irq][q_cpu]) |=> pend_q[$past(q_irq)][$past(q_cpu)]); // R4

  AST_MODEL_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_set && cmd_field == 2'd1 && model_q[cmd_irq] && rise[cmd_irq] == '0)
    |=> (pend_q[$past(cmd_irq)] == '0)); // R5

  AST_MASK_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_set && cmd_field == 2'd1 && !model_q[cmd_irq] && rise[cmd_irq] == '0)
    |=> (pend_q[$past(cmd_irq)] == ($past(pend_q[cmd_irq]) & ~$past(cmd_mask)))); // R6
endmodule

bind irq_state_tracker irq_state_tracker_chk #(
  .NCPU(NCPU), .NIRQ(NIRQ), .LEGACY_REV(LEGACY_REV)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_set(cmd_set),
  .cmd_field(cmd_field), .cmd_irq(cmd_irq), .cmd_mask(cmd_mask),
  .q_irq(q_irq), .q_cpu(q_cpu), .q_pending(q_pending),
  .en_q(en_q), .pend_q(pend_q), .lvl_q(lvl_q), .rise(rise),
  .edge_q(edge_q), .model_q(model_q)
);

// File: tb/irq_state_tracker_tb.sv
module irq_state_tracker_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] line_in = '0, leg_line = '0;
  logic         cmd_valid = 0, cmd_set = 0;
  logic [1:0]   cmd_field = '0;
  logic [5:0]   cmd_irq = '0, cfg_irq = '0, pri_irq = '0, q_irq = '0;
  logic [1:0]   cmd_mask = '0;
  logic         cfg_valid = 0, cfg_edge = 0, cfg_model = 0, pri_we = 0;
  logic         pri_cpu = 0, q_cpu = 0;
  logic [7:0]   pri_val = '0;
  logic         q_en, q_pend, q_act, q_grp, l_en, l_pend, l_act, l_grp;
  logic [7:0]   q_pri, l_pri;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_state_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .cmd_valid(cmd_valid), .cmd_set(cmd_set),
    .cmd_field(cmd_field), .cmd_irq(cmd_irq), .cmd_mask(cmd_mask), .cfg_valid(cfg_valid),
    .cfg_irq(cfg_irq), .cfg_edge(cfg_edge), .cfg_model(cfg_model), .pri_we(pri_we),
    .pri_irq(pri_irq), .pri_cpu(pri_cpu), .pri_val(pri_val), .q_irq(q_irq), .q_cpu(q_cpu),
    .q_enabled(q_en), .q_pending(q_pend), .q_active(q_act), .q_group(q_grp), .q_priority(q_pri));

  irq_state_tracker #(.LEGACY_REV(1'b1)) leg_i (
    .clk(clk), .rst_n(rst_n), .line_in(leg_line), .cmd_valid(cmd_valid), .cmd_set(cmd_set),
    .cmd_field(cmd_field), .cmd_irq(cmd_irq), .cmd_mask(cmd_mask), .cfg_valid(cfg_valid),
    .cfg_irq(cfg_irq), .cfg_edge(cfg_edge), .cfg_model(cfg_model), .pri_we(pri_we),
    .pri_irq(pri_irq), .pri_cpu(pri_cpu), .pri_val(pri_val), .q_irq(q_irq), .q_cpu(q_cpu),
    .q_enabled(l_en), .q_pending(l_pend), .q_active(l_act), .q_group(l_grp), .q_priority(l_pri));

  // {field, set, irq, mask, expected {cpu1,cpu0} of that field afterwards}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {2'd0, 1'b1, 6'd5,  2'b01, 2'b01},  // R1
    {2'd0, 1'b1, 6'd5,  2'b10, 2'b11},  // R1
    {2'd0, 1'b0, 6'd5,  2'b01, 2'b10},  // R2
    {2'd2, 1'b1, 6'd40, 2'b11, 2'b11},  // R1
    {2'd2, 1'b0, 6'd40, 2'b10, 2'b01},  // R2
    {2'd3, 1'b1, 6'd63, 2'b10, 2'b10},  // R1
    {2'd3, 1'b0, 6'd63, 2'b11, 2'b00},  // R2
    {2'd1, 1'b1, 6'd10, 2'b10, 2'b10},  // R1
    {2'd1, 1'b1, 6'd10, 2'b01, 2'b11},  // R1
    {2'd1, 1'b0, 6'd10, 2'b10, 2'b01},  // R6
    {2'd0, 1'b1, 6'd0,  2'b11, 2'b11},  // R1
    {2'd0, 1'b0, 6'd0,  2'b00, 2'b11}   // R2
  };

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] f, input logic s, input logic [5:0] irq, input logic [1:0] m);
    @(negedge clk);
    cmd_valid = 1; cmd_field = f; cmd_set = s; cmd_irq = irq; cmd_mask = m;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic cfg(input logic [5:0] irq, input logic e, input logic m);
    @(negedge clk);
    cfg_valid = 1; cfg_irq = irq; cfg_edge = e; cfg_model = m;
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic pri(input logic [5:0] irq, input logic c, input logic [7:0] v);
    @(negedge clk);
    pri_we = 1; pri_irq = irq; pri_cpu = c; pri_val = v;
    @(negedge clk);
    pri_we = 0;
  endtask

  task automatic peek(input logic [5:0] irq, input logic c);
    q_irq = irq; q_cpu = c;
    #1;
  endtask

  function automatic logic fsel(input logic [1:0] f);
    case (f)
      2'd0: return q_en;
      2'd1: return q_pend;
      2'd2: return q_act;
      default: return q_grp;
    endcase
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    peek(6'd0, 1'b0);
    check({4'd0, q_en, q_pend, q_act, q_grp}, 8'h00, "R10");
    check(q_pri, 8'h00, "R10");
    peek(6'd40, 1'b1);
    check({4'd0, q_en, q_pend, q_act, q_grp}, 8'h00, "R10");
    check(q_pri, 8'h00, "R10");

    for (int v = 0; v < NV; v++) begin
      cmd(VEC[v][12:11], VEC[v][10], VEC[v][9:4], VEC[v][3:2]);
      peek(VEC[v][9:4], 1'b0); got[0] = fsel(VEC[v][12:11]);
      peek(VEC[v][9:4], 1'b1); got[1] = fsel(VEC[v][12:11]);
      check({6'd0, got}, {6'd0, VEC[v][1:0]}, "R1/R2 table (R1 R2 R6)");
    end

    // R3, R7: level interrupt 20, cpu1 line
    @(negedge clk); line_in[20*2+1] = 1'b1;
    @(negedge clk);
    peek(6'd20, 1'b1); check({7'd0, q_pend}, 8'd1, "R3");
    peek(6'd20, 1'b0); check({7'd0, q_pend}, 8'd0, "R3");
    cmd(2'd1, 1'b0, 6'd20, 2'b11);
    peek(6'd20, 1'b1); check({7'd0, q_pend}, 8'd1, "R7");
    @(negedge clk); line_in[20*2+1] = 1'b0;
    @(negedge clk);
    peek(6'd20, 1'b1); check({7'd0, q_pend}, 8'd0, "R7");

    // R4: edge interrupt 30, cpu0 line
    cfg(6'd30, 1'b1, 1'b0);
    @(negedge clk); line_in[30*2] = 1'b1;
    @(negedge clk);
    peek(6'd30, 1'b0); check({7'd0, q_pend}, 8'd1, "R4");
    peek(6'd30, 1'b1); check({7'd0, q_pend}, 8'd0, "R4");
    cmd(2'd1, 1'b0, 6'd30, 2'b01);
    @(negedge clk);
    peek(6'd30, 1'b0); check({7'd0, q_pend}, 8'd0, "R4");
    line_in[30*2] = 1'b0;
    @(negedge clk); line_in[30*2] = 1'b1;
    @(negedge clk);
    peek(6'd30, 1'b0); check({7'd0, q_pend}, 8'd1, "R4");

    // R11: clear on the same edge as a rising line
    line_in[30*2] = 1'b0;
    cmd(2'd1, 1'b0, 6'd30, 2'b01);
    @(negedge clk);
    cmd_valid = 1; cmd_field = 2'd1; cmd_set = 0; cmd_irq = 6'd30; cmd_mask = 2'b01;
    line_in[30*2] = 1'b1;
    @(negedge clk); cmd_valid = 0;
    peek(6'd30, 1'b0); check({7'd0, q_pend}, 8'd1, "R11");

    // R5: one-of-N interrupt 45
    cfg(6'd45, 1'b1, 1'b1);
    cmd(2'd1, 1'b1, 6'd45, 2'b11);
    cmd(2'd1, 1'b0, 6'd45, 2'b01);
    peek(6'd45, 1'b0); check({7'd0, q_pend}, 8'd0, "R5");
    peek(6'd45, 1'b1); check({7'd0, q_pend}, 8'd0, "R5");

    // R8: banked and shared priorities
    pri(6'd3, 1'b0, 8'h11);
    pri(6'd3, 1'b1, 8'h22);
    peek(6'd3, 1'b0); check(q_pri, 8'h11, "R8");
    peek(6'd3, 1'b1); check(q_pri, 8'h22, "R8");
    pri(6'd50, 1'b1, 8'h80);
    peek(6'd50, 1'b0); check(q_pri, 8'h80, "R8");
    pri(6'd50, 1'b0, 8'h7f);
    peek(6'd50, 1'b1); check(q_pri, 8'h7f, "R8");

    // R9: legacy copy, level interrupt 7, cpu0 line
    @(negedge clk); leg_line[7*2] = 1'b1;
    @(negedge clk);
    peek(6'd7, 1'b0); check({7'd0, l_pend}, 8'd1, "R9");
    cmd(2'd1, 1'b0, 6'd7, 2'b01);
    peek(6'd7, 1'b0); check({7'd0, l_pend}, 8'd0, "R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule